// File: doc/BRIEF.md
# Real-Time Counter with Alarm

This block keeps time as a 48-bit up-counter that advances once on each clock edge where the tick-enable input is high. The counter is meant to be ticked at 65536 Hz, so one second is 65536 counts. A host reaches every register through a byte-wide interface with separate read and write strobes. The host can load the time one byte at a time and read it back. The read path takes a snapshot, so a multi-byte read returns a consistent value.

A 32-bit alarm value is compared against the upper 32 bits of the counter, which gives a resolution of one second. When the alarm is enabled and the compare starts to match, the block emits a single-cycle wake pulse intended for power-up logic; there is no interrupt line. A control register holds three pins: oscillator bypass, alarm enable and clock-buffer disable. It also holds a sticky "time valid" flag. Software can set that flag but cannot clear it, so it records whether the time has been set since the last power-domain reset.

Top module: `rtc_alarm_top`

## Requirements
- R1: The 48-bit counter increments by exactly one on each clock edge where `tick_en` is high, wraps from all ones to zero, and holds when `tick_en` is low and no counter byte is written.
- R2: A write to address 0x5A+k (k = 0..5) loads counter byte k (bits 8k+7:8k, least significant at 0x5A) and leaves the other bytes alone. In a cycle that both ticks and writes, the addressed byte takes the written value and the other bytes take the incremented value.
- R3: A read of 0x5A returns live counter byte 0 and copies all six counter bytes into a snapshot. Reads of 0x5B..0x5F return snapshot bytes 1..5 and are unaffected by ticks since that copy.
- R4: Alarm bytes sit at 0x56..0x59 and map to counter bits 23:16, 31:24, 39:32 and 47:40 in that order. They are writable and read back as written.
- R5: The alarm matches when the four alarm bytes equal counter bits 47:16. Counter bits 15:0 play no part, so a match holds for 65536 ticks.
- R6: `wake_pulse` is high for exactly one cycle each time (alarm enabled AND match) goes from false to true. It never rises while the alarm enable is off.
- R7: The control register at 0x53 drives three pins: bit 1 to `osc_bypass` (1 = bypass), bit 3 to `clkbuf_off` (1 = disabled), and bit 2 as the alarm enable. Bits 7:1 are writable and read back as written.
- R8: Control bit 0 (`time_valid`) is set by writing 1 to it. Writing 0 has no effect, and only `rst_n` clears it.
- R9: Addresses outside 0x53, 0x56..0x59 and 0x5A..0x5F read as 0x00, and writes to them change no register.
- R10: After `rst_n` the control register reads 0x30 (bit 0 clear), the counter and alarm read zero, and `wake_pulse` is low.
- R11: Read data is registered. `rdata` changes on the clock edge that samples `rd_en` and keeps its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-domain reset |
| tick_en | input | 1 | Advance the counter by one on this edge |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| rd_en | input | 1 | Read strobe for `addr` |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| wake_pulse | output | 1 | One-cycle alarm wake event |
| osc_bypass | output | 1 | Control bit 1: oscillator bypass |
| clkbuf_off | output | 1 | Control bit 3: clock buffer disable |
| time_valid | output | 1 | Sticky control bit 0 |

## Verification
A corrupted counter byte is visible at the next read of that byte. A stale or torn snapshot shows up as soon as bytes 1..5 are read after ticks that carry into them. A wrong compare width or a wrong alarm byte order moves the wake pulse away from the 65536-count boundary where it should fire. An edge detector that is stuck shows up as no pulse, or as more than one pulse, across a 100-tick run. A sticky flag that can be cleared shows up in the readback of 0x53 right after a write of 0.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int ADDR_W      = 8;
    localparam int CNT_BYTES   = 6;
    localparam int ALM_BYTES   = 4;
    localparam int CNT_W       = CNT_BYTES * 8;
    localparam int ALM_W       = ALM_BYTES * 8;
    localparam int ALM_LSB     = CNT_W - ALM_W;

    localparam logic [ADDR_W-1:0] ADDR_CTRL     = 8'h53;
    localparam logic [ADDR_W-1:0] ADDR_ALM_BASE = 8'h56;
    localparam logic [ADDR_W-1:0] ADDR_CNT_BASE = 8'h5A;

    localparam logic [7:0] CTRL_RESET = 8'h30;
    localparam int BIT_VALID  = 0;
    localparam int BIT_BYPASS = 1;
    localparam int BIT_ALM_EN = 2;
    localparam int BIT_BUFOFF = 3;
endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] ctrl_o
);
    typedef struct packed {
        logic [7:0] ctrl;
    } ctrl_state_t;

    ctrl_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_i) begin
            state_d.ctrl[7:1]       = wdata_i[7:1];
            state_d.ctrl[BIT_VALID] = state_q.ctrl[BIT_VALID] | wdata_i[BIT_VALID];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '{ctrl: CTRL_RESET};
        else        state_q <= state_d;
    end

    assign ctrl_o = state_q.ctrl;

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[BIT_VALID] |=> ctrl_o[BIT_VALID]); // R8
endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter #(
    parameter int NBYTES = 6,
    localparam int W = NBYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [NBYTES-1:0] wsel_i,
    input  logic [7:0]        wdata_i,
    input  logic              snap_i,
    output logic [W-1:0]      count_o,
    output logic [W-1:0]      shadow_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] shadow;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.cnt = state_q.cnt + {{(W-1){1'b0}}, tick_i};
        for (int b = 0; b < NBYTES; b++) begin
            if (wsel_i[b]) state_d.cnt[b*8 +: 8] = wdata_i;
        end
        if (snap_i) state_d.shadow = state_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign count_o  = state_q.cnt;
    assign shadow_o = state_q.shadow;

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && wsel_i == '0) |=> $stable(count_o)); // R1
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && wsel_i == '0) |=> (count_o == $past(count_o) + 1'b1)); // R1
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_i |=> $stable(shadow_o)); // R3
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
    parameter int NBYTES = 4,
    parameter int CNT_W  = 48,
    localparam int W     = NBYTES * 8,
    localparam int LSB   = CNT_W - W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NBYTES-1:0] wsel_i,
    input  logic [7:0]        wdata_i,
    input  logic              en_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [W-1:0]      alarm_o,
    output logic              wake_o
);
    typedef struct packed {
        logic [W-1:0] alarm;
        logic         hit;
        logic         wake;
    } alm_state_t;

    alm_state_t state_d, state_q;
    logic       hit_now;

    always_comb begin
        state_d = state_q;
        for (int b = 0; b < NBYTES; b++) begin
            if (wsel_i[b]) state_d.alarm[b*8 +: 8] = wdata_i;
        end
        hit_now       = en_i && (state_q.alarm == count_i[CNT_W-1:LSB]);
        state_d.hit   = hit_now;
        state_d.wake  = hit_now && !state_q.hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign alarm_o = state_q.alarm;
    assign wake_o  = state_q.wake;

    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o); // R6
    AST_WAKE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> $past(en_i)); // R6
endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              wake_pulse,
    output logic              osc_bypass,
    output logic              clkbuf_off,
    output logic              time_valid
);
    typedef struct packed {
        logic [7:0] rdata;
    } top_state_t;

    top_state_t state_d, state_q;

    logic [CNT_BYTES-1:0] cnt_hit;
    logic [ALM_BYTES-1:0] alm_hit;
    logic                 ctrl_hit;
    logic                 any_hit;
    logic [7:0]           ctrl;
    logic [CNT_W-1:0]     count;
    logic [CNT_W-1:0]     shadow;
    logic [ALM_W-1:0]     alarm;
    logic [7:0]           rd_val;

    for (genvar g = 0; g < CNT_BYTES; g++) begin : g_cnt_dec
        assign cnt_hit[g] = (addr == ADDR_CNT_BASE + ADDR_W'(g));
    end
    for (genvar g = 0; g < ALM_BYTES; g++) begin : g_alm_dec
        assign alm_hit[g] = (addr == ADDR_ALM_BASE + ADDR_W'(g));
    end
    assign ctrl_hit = (addr == ADDR_CTRL);
    assign any_hit  = ctrl_hit || (|cnt_hit) || (|alm_hit);

    rtc_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_en && ctrl_hit),
        .wdata_i (wdata),
        .ctrl_o  (ctrl)
    );

    rtc_time_counter #(.NBYTES(CNT_BYTES)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_en),
        .wsel_i   (cnt_hit & {CNT_BYTES{wr_en}}),
        .wdata_i  (wdata),
        .snap_i   (rd_en && cnt_hit[0]),
        .count_o  (count),
        .shadow_o (shadow)
    );

    rtc_alarm_cmp #(.NBYTES(ALM_BYTES), .CNT_W(CNT_W)) u_alm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wsel_i  (alm_hit & {ALM_BYTES{wr_en}}),
        .wdata_i (wdata),
        .en_i    (ctrl[BIT_ALM_EN]),
        .count_i (count),
        .alarm_o (alarm),
        .wake_o  (wake_pulse)
    );

    always_comb begin
        rd_val = 8'h00;
        if (ctrl_hit) rd_val = ctrl;
        for (int b = 0; b < ALM_BYTES; b++) begin
            if (alm_hit[b]) rd_val = alarm[b*8 +: 8];
        end
        if (cnt_hit[0]) rd_val = count[7:0];
        for (int b = 1; b < CNT_BYTES; b++) begin
            if (cnt_hit[b]) rd_val = shadow[b*8 +: 8];
        end
        state_d = state_q;
        if (rd_en) state_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rdata      = state_q.rdata;
    assign osc_bypass = ctrl[BIT_BYPASS];
    assign clkbuf_off = ctrl[BIT_BUFOFF];
    assign time_valid = ctrl[BIT_VALID];

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !any_hit) |=> (rdata == 8'h00)); // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R11
    AST_ONE_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_hit, cnt_hit, alm_hit})); // R9
endmodule

// File: tb/rtc_alarm_top_tb.sv
module rtc_alarm_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       wake_pulse, osc_bypass, clkbuf_off, time_valid;

    int errors = 0;
    int checks = 0;
    int wake_cnt = 0;

    always #2 clk = ~clk;

    rtc_alarm_top u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .wake_pulse(wake_pulse),
        .osc_bypass(osc_bypass), .clkbuf_off(clkbuf_off), .time_valid(time_valid)
    );

    always @(negedge clk) if (wake_pulse) wake_cnt++;

    // kind(1: read-expect, 0: write), addr, data, requirement tag
    localparam int NV = 20;
    localparam logic [40:0] VEC [NV] = '{
        {1'b1, 8'h53, 8'h30, "R10"},
        {1'b1, 8'h5A, 8'h00, "R10"},
        {1'b1, 8'h58, 8'h00, "R10"},
        {1'b0, 8'h53, 8'h00, "R8 "},
        {1'b1, 8'h53, 8'h00, "R8 "},
        {1'b0, 8'h53, 8'h01, "R8 "},
        {1'b1, 8'h53, 8'h01, "R8 "},
        {1'b0, 8'h53, 8'h30, "R8 "},
        {1'b1, 8'h53, 8'h31, "R8 "},
        {1'b0, 8'h5C, 8'hA5, "R2 "},
        {1'b0, 8'h5F, 8'h3C, "R2 "},
        {1'b1, 8'h5A, 8'h00, "R3 "},
        {1'b1, 8'h5C, 8'hA5, "R2 "},
        {1'b1, 8'h5F, 8'h3C, "R2 "},
        {1'b1, 8'h5D, 8'h00, "R2 "},
        {1'b0, 8'h57, 8'h11, "R4 "},
        {1'b1, 8'h57, 8'h11, "R4 "},
        {1'b0, 8'h40, 8'hFF, "R9 "},
        {1'b1, 8'h40, 8'h00, "R9 "},
        {1'b1, 8'h52, 8'h00, "R9 "}
    };

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0;
        chk(tag, rdata, exp);
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic set_cnt(input logic [47:0] v);
        for (int b = 0; b < 6; b++) wr(8'h5A + 8'(b), v[b*8 +: 8]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R10", {7'd0, wake_pulse}, 8'h00);
        chk("R10", {7'd0, time_valid}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            string tg;
            tg = $sformatf("%s", VEC[i][23:0]);
            if (VEC[i][40]) rd(VEC[i][39:32], VEC[i][31:24], tg);
            else            wr(VEC[i][39:32], VEC[i][31:24]);
        end

        // R3: snapshot coherence across a carry into byte 2
        set_cnt(48'h0000_0000_FFFF);
        rd(8'h5A, 8'hFF, "R3");
        ticks(5);
        rd(8'h5B, 8'hFF, "R3");
        rd(8'h5C, 8'h00, "R3");
        rd(8'h5A, 8'h04, "R1");
        rd(8'h5C, 8'h01, "R1");
        rd(8'h5B, 8'h00, "R1");

        // R1: wrap from all ones
        set_cnt(48'hFFFF_FFFF_FFFF);
        ticks(1);
        rd(8'h5A, 8'h00, "R1");
        rd(8'h5F, 8'h00, "R1");

        // R2: tick and byte write in the same cycle
        set_cnt(48'h0000_0000_0010);
        @(negedge clk); tick_en = 1'b1; wr_en = 1'b1; addr = 8'h5C; wdata = 8'h07;
        @(negedge clk); tick_en = 1'b0; wr_en = 1'b0;
        rd(8'h5A, 8'h11, "R2");
        rd(8'h5C, 8'h07, "R2");

        // R11: rdata stays until the sampling edge
        rd(8'h53, 8'h31, "R11");
        @(negedge clk); rd_en = 1'b1; addr = 8'h57;
        #1 chk("R11", rdata, 8'h31);
        @(negedge clk); rd_en = 1'b0;
        chk("R11", rdata, 8'h11);

        // R5/R6: alarm at upper bits 0x00000002
        wr(8'h53, 8'h31);
        wr(8'h56, 8'h02); wr(8'h57, 8'h00); wr(8'h58, 8'h00); wr(8'h59, 8'h00);
        rd(8'h56, 8'h02, "R4");
        set_cnt(48'h0000_0001_FFF0);
        wr(8'h53, 8'h35);
        wake_cnt = 0;
        ticks(10);
        repeat (2) @(negedge clk);
        chk("R5", 8'(wake_cnt), 8'd0);
        ticks(90);
        repeat (3) @(negedge clk);
        chk("R6", 8'(wake_cnt), 8'd1);

        // R6: disabled alarm crosses the match silently
        wr(8'h53, 8'h31);
        set_cnt(48'h0000_0001_FFF0);
        wake_cnt = 0;
        ticks(100);
        repeat (3) @(negedge clk);
        chk("R6", 8'(wake_cnt), 8'd0);

        // R5: match with nonzero low 16 bits, then enable
        set_cnt(48'h0000_0002_1234);
        wake_cnt = 0;
        wr(8'h53, 8'h35);
        repeat (3) @(negedge clk);
        chk("R5", 8'(wake_cnt), 8'd1);

        // R7: control pins
        wr(8'h53, 8'h3A);
        chk("R7", {6'd0, osc_bypass, clkbuf_off}, 8'h03);
        chk("R8", {7'd0, time_valid}, 8'h01);
        rd(8'h53, 8'h3B, "R7");

        // R10: power-domain reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R10", {7'd0, time_valid}, 8'h00);
        rd(8'h53, 8'h30, "R10");
        rd(8'h5A, 8'h00, "R10");
        rd(8'h56, 8'h00, "R10");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule